// File: doc/BRIEF.md
# Segmented DAC Linearity Correction Engine

This block sits between a controller and the serial writer of a multi-channel string DAC. It takes a requested code and a channel number and returns a corrected code for that channel. The correction comes from a per-channel table of piecewise-linear segments. The upper code bits pick a segment. The table gives that segment an offset (the correction at the segment's first code) and a slope (the change in correction up to the start of the next segment). The lower code bits then set how far along the segment the slope is applied.

Coefficients are loaded through a separate write port, one coefficient at a time. After reset every coefficient reads as zero, so codes pass through unchanged until the table is calibrated. A request passes through a registered table read and then one arithmetic register. Valid/ready handshakes on the input and the output allow back-pressure. The output carries the channel number so that it can be forwarded directly to the converter link.

Top module: `dlc_engine`

## Requirements
- R1: After reset `out_valid_o` is 0, `in_ready_o` is 1, and every coefficient reads as zero, so any code on any channel comes out unchanged.
- R2: With `SEG_W` segment bits (default 7), the segment index is `in_code_i[13:14-SEG_W]` and the fraction is the remaining low bits. With the default this gives 128 segments of 128 codes; with `SEG_W`=6 it gives 64 segments of 256 codes.
- R3: The offset C and the slope M are 6-bit two's-complement values in LSBs. The correction is C + floor((M*frac + 2^(F-1)) / 2^F), where F is the fraction width, so halves round toward plus infinity.
- R4: The output code is the input code plus the correction, clamped to 0..16383. It never wraps.
- R5: Each of the 32 channels has its own table. A write to one channel leaves the results of the other channels unchanged.
- R6: A write sets one coefficient, addressed by channel, segment and `wr_sel_i` (0 selects C, 1 selects M). The other coefficient of that segment is not changed.
- R7: A request accepted in the same cycle as a write to the entry it reads uses the value from before the write. Later requests use the new value.
- R8: A request is accepted on a clock edge where `in_valid_i` and `in_ready_o` are both high. While `out_valid_o` is high and `out_ready_i` is low, the output code and channel hold steady. Once both stages are full, `in_ready_o` goes low. Results leave in acceptance order and none are lost.
- R9: `out_ch_o` equals the channel of the request that produced the result.
- R10: When `out_ready_i` is high, a request accepted at edge k appears with `out_valid_o` high after edge k+1. It is not yet visible after edge k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request valid |
| in_ready_o | output | 1 | Request can be accepted |
| in_code_i | input | 14 | Requested code |
| in_ch_i | input | 5 | Requested channel |
| out_valid_o | output | 1 | Corrected result valid |
| out_ready_i | input | 1 | Downstream can take the result |
| out_code_o | output | 14 | Corrected code |
| out_ch_o | output | 5 | Channel of the result |
| wr_en_i | input | 1 | Coefficient write strobe |
| wr_ch_i | input | 5 | Write channel |
| wr_seg_i | input | SEG_W | Write segment index |
| wr_sel_i | input | 1 | 0 = offset C, 1 = slope M |
| wr_coef_i | input | 6 | Coefficient value, two's complement |

## Verification
Codes at fraction 0, mid-segment and the last code of a segment separate the offset term from the slope term and from the rounding. A negative slope whose product lands exactly on a half exposes floor-versus-truncate errors. Codes near 0 and 16383, with extreme offsets, show whether the sum wraps or clamps. A second instance with 256-code segments gets the same code as the default one, which tells the two index splits apart. Same-channel and other-channel reads after writes, a same-cycle write and read, and a stalled burst of three requests cover table isolation, read-before-write ordering and back-pressure.

// File: rtl/dlc_pkg.sv
package dlc_pkg;
  localparam int DEF_CODE_W = 14;
  localparam int DEF_CH_W   = 5;
  localparam int DEF_SEG_W  = 7;
  localparam int DEF_COEF_W = 6;
  localparam logic SEL_C = 1'b0;
  localparam logic SEL_M = 1'b1;
endpackage

// File: rtl/dlc_coef_bank.sv
module dlc_coef_bank #(
  parameter int AW     = 12,
  parameter int COEF_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [COEF_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [COEF_W-1:0] rd_data_o
);
  localparam int DEPTH = 1 << AW;

  logic [COEF_W-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0]  set_q;   // entry written since reset; unset entries read zero
  logic [COEF_W-1:0] rd_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      set_q <= '0;
    else if (wr_en_i) set_q[wr_addr_i] <= 1'b1;
  end

  // read samples pre-write contents on a same-cycle collision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_q <= '0;
    else if (rd_en_i) rd_q <= set_q[rd_addr_i] ? mem_q[rd_addr_i] : '0;
  end

  assign rd_data_o = rd_q;

  a_r8_rd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

// File: rtl/dlc_interp.sv
module dlc_interp #(
  parameter int CODE_W = 14,
  parameter int SEG_W  = 7,
  parameter int COEF_W = 6
) (
  input  logic [CODE_W-1:0]        code_i,
  input  logic signed [COEF_W-1:0] c_i,
  input  logic signed [COEF_W-1:0] m_i,
  output logic [CODE_W-1:0]        code_o
);
  localparam int F_W   = CODE_W - SEG_W;
  localparam int P_W   = COEF_W + F_W + 1;
  localparam int S_W   = ((P_W > CODE_W) ? P_W : CODE_W) + 2;
  localparam int HALF  = 1 << (F_W - 1);
  localparam int MAXC  = (1 << CODE_W) - 1;

  logic [F_W-1:0]         frac;
  logic signed [P_W-1:0]  prod;
  logic signed [P_W-1:0]  slope_term;
  logic signed [S_W-1:0]  corr;
  logic signed [S_W-1:0]  sum;

  always_comb begin
    frac       = code_i[F_W-1:0];
    prod       = P_W'(m_i) * P_W'($signed({1'b0, frac}));
    slope_term = (prod + P_W'(HALF)) >>> F_W;
    corr       = S_W'(c_i) + S_W'(slope_term);
    sum        = $signed({{(S_W-CODE_W){1'b0}}, code_i}) + corr;
    if (sum < 0)                code_o = '0;
    else if (sum > S_W'(MAXC))  code_o = CODE_W'(MAXC);
    else                        code_o = sum[CODE_W-1:0];
  end

  always_comb begin
    if (m_i == '0) a_r3_zero_slope: assert (corr == S_W'(c_i));
    if (corr >= 0) a_r4_no_wrap_up: assert (code_o >= code_i);
    else           a_r4_no_wrap_dn: assert (code_o <= code_i);
  end
endmodule

// File: rtl/dlc_engine.sv
module dlc_engine #(
  parameter int CODE_W = dlc_pkg::DEF_CODE_W,
  parameter int CH_W   = dlc_pkg::DEF_CH_W,
  parameter int SEG_W  = dlc_pkg::DEF_SEG_W,
  parameter int COEF_W = dlc_pkg::DEF_COEF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [CODE_W-1:0] in_code_i,
  input  logic [CH_W-1:0]   in_ch_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [CODE_W-1:0] out_code_o,
  output logic [CH_W-1:0]   out_ch_o,
  input  logic              wr_en_i,
  input  logic [CH_W-1:0]   wr_ch_i,
  input  logic [SEG_W-1:0]  wr_seg_i,
  input  logic              wr_sel_i,
  input  logic [COEF_W-1:0] wr_coef_i
);
  localparam int AW = CH_W + SEG_W;

  logic              rd_en;
  logic              out_ld;
  logic              s1_vld_q;
  logic [CODE_W-1:0] s1_code_q;
  logic [CH_W-1:0]   s1_ch_q;
  logic [COEF_W-1:0] coef [2];
  logic [CODE_W-1:0] corr_code;
  logic              out_vld_q;
  logic [CODE_W-1:0] out_code_q;
  logic [CH_W-1:0]   out_ch_q;
  logic [AW-1:0]     rd_addr;
  logic [AW-1:0]     wr_addr;

  assign out_ld     = s1_vld_q && (!out_vld_q || out_ready_i);
  assign in_ready_o = !s1_vld_q || out_ld;
  assign rd_en      = in_valid_i && in_ready_o;
  assign rd_addr    = {in_ch_i, in_code_i[CODE_W-1 -: SEG_W]};
  assign wr_addr    = {wr_ch_i, wr_seg_i};

  for (genvar b = 0; b < 2; b++) begin : g_bank
    localparam logic SEL = (b == 0) ? dlc_pkg::SEL_C : dlc_pkg::SEL_M;
    dlc_coef_bank #(.AW(AW), .COEF_W(COEF_W)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en_i && (wr_sel_i == SEL)),
      .wr_addr_i (wr_addr),
      .wr_data_i (wr_coef_i),
      .rd_en_i   (rd_en),
      .rd_addr_i (rd_addr),
      .rd_data_o (coef[b])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld_q  <= 1'b0;
      s1_code_q <= '0;
      s1_ch_q   <= '0;
    end else if (in_ready_o) begin
      s1_vld_q <= in_valid_i;
      if (in_valid_i) begin
        s1_code_q <= in_code_i;
        s1_ch_q   <= in_ch_i;
      end
    end
  end

  dlc_interp #(.CODE_W(CODE_W), .SEG_W(SEG_W), .COEF_W(COEF_W)) u_interp (
    .code_i (s1_code_q),
    .c_i    ($signed(coef[0])),
    .m_i    ($signed(coef[1])),
    .code_o (corr_code)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_vld_q  <= 1'b0;
      out_code_q <= '0;
      out_ch_q   <= '0;
    end else if (!out_vld_q || out_ready_i) begin
      out_vld_q <= s1_vld_q;
      if (s1_vld_q) begin
        out_code_q <= corr_code;
        out_ch_q   <= s1_ch_q;
      end
    end
  end

  assign out_valid_o = out_vld_q;
  assign out_code_o  = out_code_q;
  assign out_ch_o    = out_ch_q;

  a_r8_out_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_code_o) && $stable(out_ch_o));
  a_r8_full_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i && s1_vld_q |-> !in_ready_o);
  a_r10_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en |=> s1_vld_q);
  a_r10_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_ld |=> out_valid_o);
endmodule

// File: tb/dlc_engine_tb.sv
module dlc_engine_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [13:0] in_code = '0;
  logic [4:0]  in_ch = '0;
  logic        out_ready = 1'b1;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_ch = '0;
  logic [6:0]  wr_seg = '0;
  logic        wr_sel = 1'b0;
  logic [5:0]  wr_coef = '0;
  logic        in_ready, out_valid, in_ready6, out_valid6;
  logic [13:0] out_code, out_code6;
  logic [4:0]  out_ch, out_ch6;

  int nvec = 0;
  int nfail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dlc_engine u_dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_code_i(in_code), .in_ch_i(in_ch), .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_code_o(out_code), .out_ch_o(out_ch), .wr_en_i(wr_en), .wr_ch_i(wr_ch),
    .wr_seg_i(wr_seg), .wr_sel_i(wr_sel), .wr_coef_i(wr_coef));

  dlc_engine #(.SEG_W(6)) u_dut_s6 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready6),
    .in_code_i(in_code), .in_ch_i(in_ch), .out_valid_o(out_valid6), .out_ready_i(out_ready),
    .out_code_o(out_code6), .out_ch_o(out_ch6), .wr_en_i(wr_en), .wr_ch_i(wr_ch),
    .wr_seg_i(wr_seg[5:0]), .wr_sel_i(wr_sel), .wr_coef_i(wr_coef));

  function automatic int model(int code, int c, int m, int segw);
    int fw = 14 - segw;
    int frac = code & ((1 << fw) - 1);
    int r = (m * frac + (1 << (fw - 1))) >>> fw;
    int s = code + c + r;
    if (s < 0) s = 0;
    if (s > 16383) s = 16383;
    return s;
  endfunction

  task automatic check(string req, int act, int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(int ch, int seg, bit sel, int val);
    @(negedge clk);
    wr_en = 1'b1; wr_ch = 5'(ch); wr_seg = 7'(seg); wr_sel = sel; wr_coef = 6'(val);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // accept, then sample one and two edges later (R10 latency)
  task automatic send(int ch, int code, int exp, string req);
    @(negedge clk);
    in_valid = 1'b1; in_code = 14'(code); in_ch = 5'(ch);
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 not after one edge", int'(out_valid), 0);
    @(negedge clk);
    check("R10 valid after two edges", int'(out_valid), 1);
    check(req, int'(out_code), exp);
    check("R9 channel", int'(out_ch), ch);
  endtask

  task automatic t_reset();
    check("R1 out_valid reset", int'(out_valid), 0);
    check("R1 in_ready reset", int'(in_ready), 1);
    send(0, 0, 0, "R1 passthrough 0");
    send(5, 8191, 8191, "R1 passthrough mid");
    send(31, 16383, 16383, "R1 passthrough top");
  endtask

  task automatic t_seg_split();
    wr(0, 1, 1'b0, 4);
    wr(0, 1, 1'b1, 16);
    send(0, 384, 384, "R2 7-bit split, seg 3 untouched");
    check("R2 6-bit split seg 1", int'(out_code6), model(384, 4, 16, 6));
  endtask

  task automatic t_interp();
    wr(3, 10, 1'b0, -3);
    wr(3, 10, 1'b1, 20);
    send(3, 1280, model(1280, -3, 20, 7), "R3 frac 0");
    send(3, 1344, model(1344, -3, 20, 7), "R3 frac mid");
    send(3, 1407, model(1407, -3, 20, 7), "R3 frac last");
    send(3, 1408, 1408, "R2 next segment untouched");
    wr(3, 11, 1'b1, -20);
    send(3, 1440, model(1440, 0, -20, 7), "R3 negative slope half");
    send(3, 1504, model(1504, 0, -20, 7), "R3 negative slope");
  endtask

  task automatic t_sel();
    wr(3, 12, 1'b0, 7);
    send(3, 1636, 1643, "R6 C only, M stays zero");
    wr(3, 12, 1'b1, -8);
    send(3, 1636, model(1636, 7, -8, 7), "R6 M write keeps C");
  endtask

  task automatic t_channel();
    send(4, 1344, 1344, "R5 other channel unaffected");
    send(3, 1344, model(1344, -3, 20, 7), "R5 own channel kept");
  endtask

  task automatic t_sat();
    wr(31, 127, 1'b0, 31);
    send(31, 16383, 16383, "R4 clamp at top code");
    send(31, 16370, 16383, "R4 clamp above max");
    send(31, 16300, 16331, "R4 near top no clamp");
    wr(31, 0, 1'b0, -32);
    send(31, 10, 0, "R4 clamp below zero");
    send(31, 40, 8, "R4 near zero no clamp");
  endtask

  task automatic t_collision();
    @(negedge clk);
    wr_en = 1'b1; wr_ch = 5'd7; wr_seg = 7'd20; wr_sel = 1'b0; wr_coef = 6'd9;
    in_valid = 1'b1; in_code = 14'((20 << 7) + 5); in_ch = 5'd7;
    @(negedge clk);
    wr_en = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    check("R7 collision returns old", int'(out_code), (20 << 7) + 5);
    send(7, (20 << 7) + 5, (20 << 7) + 14, "R7 later read sees new");
  endtask

  task automatic t_stall();
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_code = 14'd100; in_ch = 5'd1;
    @(negedge clk);
    in_code = 14'd200; in_ch = 5'd2;
    @(negedge clk);
    in_code = 14'd300; in_ch = 5'd6;
    @(negedge clk);
    check("R8 ready low when full", int'(in_ready), 0);
    check("R8 first result held", int'(out_code), 100);
    @(negedge clk);
    check("R8 still held", int'(out_code), 100);
    check("R8 channel held", int'(out_ch), 1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 second in order", int'(out_code), 200);
    check("R9 second channel", int'(out_ch), 2);
    @(negedge clk);
    check("R8 third in order", int'(out_code), 300);
    check("R8 third valid", int'(out_valid), 1);
    @(negedge clk);
    check("R8 drained", int'(out_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_seg_split();
    t_interp();
    t_sel();
    t_channel();
    t_sat();
    t_collision();
    t_stall();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nvec++;
    nfail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule